// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked system reach an external asynchronous static RAM of 32K words by 8 bits. On the system side a request is offered with a valid/ready handshake. It carries a 15-bit address, a read/write flag and, for writes, an 8-bit data word. A read returns its word on a one-cycle data-valid strobe. On the RAM side the controller drives the address, three active-low strobes (chip enable, write enable, output enable), the outgoing data value and the enable of its own data drivers. It also samples the incoming data value.

Every phase length is a clock count. It is worked out at elaboration as the ceiling of a nanosecond limit divided by the clock period. The defaults suit the slower 70 ns speed grade at 100 MHz. The controller owns the rules on bus turnaround and strobe overlap. Write enable is high on every address change. A write lasts for the overlap of chip enable and write enable, and both end it together. The controller's drivers stay off while the RAM may still be driving the shared pins after a read.

Top module: `asram_bridge`

## Requirements
- R1: During and after reset, until a request is accepted: chip enable, write enable and output enable are high (1), the data driver enable is low (0), ready is high and read-data-valid is low.
- R2: A read accepted at a clock edge puts the request address on the RAM address in the next cycle. Chip enable and output enable are then low and write enable high for exactly RD_CYC cycles (default ceil(70/10) = 7).
- R3: A read captures the incoming RAM data on the last of the RD_CYC access cycles. In the next cycle chip enable and output enable rise together, read data holds the captured word, and read-data-valid is high for exactly that one cycle.
- R4: A write accepted at a clock edge first spends one cycle with the new address on the RAM address and all strobes high. Chip enable and write enable are then low, with output enable high, for exactly WR_CYC cycles (default max(ceil(40/10), ceil(40/10), ceil(70/10)) = 7).
- R5: The data drivers are enabled from the first write-enable-low cycle until one cycle after write enable returns high. Throughout that time the outgoing data equals the request's write data.
- R6: The data drivers are never enabled while output enable is low. After output enable rises at the end of a read, at least TURN_CYC cycles (default ceil(35/10) = 4) pass with the drivers off before they are enabled again.
- R7: The RAM address changes only at an edge where write enable is high both before and after it.
- R8: Ready falls at the accepting edge and stays low for RD_CYC + TURN_CYC cycles after a read (11 by default) or WR_CYC + 2 after a write (9 by default). Requests offered while ready is low are ignored: no strobe activity, no address change, no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle; request accepted when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle strobe: rd_data holds read result |
| rd_data | output | 8 | Read result |
| ram_addr | output | 15 | RAM address |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dq_out | output | 8 | Value for the shared data pins |
| ram_dq_oe | output | 1 | Enable of the controller's data drivers |
| ram_dq_in | input | 8 | Value sampled from the shared data pins |

## Verification
The properties assume the RAM returns settled data by the last access cycle, and that the requester holds its request fields steady in the accepting cycle. The bench's RAM model drives the data pins only while chip and output enable are low and write enable is high, and changes only on clock edges. The requester drives inputs at falling edges. It also offers stray requests only while ready is low, to exercise the ignore rule without racing the acceptance edge.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_RD_REC   = 3'd2,
    ST_WR_ADDR  = 3'd3,
    ST_WR_PULSE = 3'd4,
    ST_WR_HOLD  = 3'd5
  } asram_state_e;

  // Ceiling of a nanosecond limit over the clock period, never below one cycle.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    return max2(max2(a, b), c);
  endfunction

  // Bits needed to hold values 0..n.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int unsigned RD_CYC   = 7,
  parameter int unsigned TURN_CYC = 4,
  parameter int unsigned WR_CYC   = 7,
  parameter int unsigned CW       = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic last_acc,
  output logic ram_ce_n,
  output logic ram_we_n,
  output logic ram_oe_n,
  output logic ram_dq_oe
);

  asram_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign last_acc  = (state_q == ST_RD_ACC) && (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_write) begin
            state_d = ST_WR_ADDR;
          end else begin
            state_d = ST_RD_ACC;
            cnt_d   = CW'(RD_CYC - 1);
          end
        end
      end
      ST_RD_ACC: begin
        if (cnt_q == '0) begin
          state_d = ST_RD_REC;
          cnt_d   = CW'(TURN_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RD_REC: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_WR_ADDR: begin
        state_d = ST_WR_PULSE;
        cnt_d   = CW'(WR_CYC - 1);
      end
      ST_WR_PULSE: begin
        if (cnt_q == '0) state_d = ST_WR_HOLD;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_WR_HOLD: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // Strobes are registered from the next state so the RAM pins never see decode glitches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      ram_ce_n  <= 1'b1;
      ram_we_n  <= 1'b1;
      ram_oe_n  <= 1'b1;
      ram_dq_oe <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      ram_ce_n  <= !((state_d == ST_RD_ACC) || (state_d == ST_WR_PULSE));
      ram_we_n  <= !(state_d == ST_WR_PULSE);
      ram_oe_n  <= !(state_d == ST_RD_ACC);
      ram_dq_oe <= (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
    end
  end

  // R2: an enabled RAM output always comes with chip enable low and write enable high
  a_r2_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe_n |-> (ram_we_n && !ram_ce_n));

  // R3: output enable and chip enable are released on the same edge
  a_r3_joint_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_oe_n) |-> $rose(ram_ce_n));

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          last_acc,
  input  logic [DW-1:0] ram_dq_in,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_dq_out,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_addr   <= '0;
      ram_dq_out <= '0;
    end else if (accept) begin
      ram_addr <= req_addr;
      if (req_write) ram_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= last_acc;
      if (last_acc) rd_data <= ram_dq_in;
    end
  end

  // R3: the read-data-valid strobe is a single cycle
  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/asram_bridge.sv
module asram_bridge
  import asram_pkg::*;
#(
  parameter int unsigned AW       = 15,
  parameter int unsigned DW       = 8,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned T_AA_NS  = 70,
  parameter int unsigned T_OE_NS  = 35,
  parameter int unsigned T_WP_NS  = 40,
  parameter int unsigned T_DW_NS  = 40,
  parameter int unsigned T_WC_NS  = 70,
  parameter int unsigned T_HZ_NS  = 35
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] ram_addr,
  output logic          ram_ce_n,
  output logic          ram_we_n,
  output logic          ram_oe_n,
  output logic [DW-1:0] ram_dq_out,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_in
);

  localparam int unsigned RD_CYC   = max2(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int unsigned WR_CYC   = max3(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS),
                                          ns_to_cyc(T_WC_NS, CLK_NS));
  localparam int unsigned TURN_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned CW       = cnt_bits(max3(RD_CYC, WR_CYC, TURN_CYC));

  logic accept;
  logic last_acc;

  asram_fsm #(
    .RD_CYC  (RD_CYC),
    .TURN_CYC(TURN_CYC),
    .WR_CYC  (WR_CYC),
    .CW      (CW)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_ready(req_ready),
    .accept   (accept),
    .last_acc (last_acc),
    .ram_ce_n (ram_ce_n),
    .ram_we_n (ram_we_n),
    .ram_oe_n (ram_oe_n),
    .ram_dq_oe(ram_dq_oe)
  );

  asram_datapath #(
    .AW(AW),
    .DW(DW)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .last_acc  (last_acc),
    .ram_dq_in (ram_dq_in),
    .ram_addr  (ram_addr),
    .ram_dq_out(ram_dq_out),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  // Run-length observers on the pins, independent of the sequencer's own counter.
  logic [CW-1:0] we_run, oe_run, since_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run   <= '0;
      oe_run   <= '0;
      since_oe <= '1;
    end else begin
      we_run   <= ram_we_n ? '0 : ((we_run == '1) ? we_run : we_run + 1'b1);
      oe_run   <= ram_oe_n ? '0 : ((oe_run == '1) ? oe_run : oe_run + 1'b1);
      since_oe <= !ram_oe_n ? '0 : ((since_oe == '1) ? since_oe : since_oe + 1'b1);
    end
  end

  // R2: output enable stays low for the full access count
  a_r2_access_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_oe_n) |-> (oe_run == CW'(RD_CYC)));

  // R4: write enable stays low for the full write count
  a_r4_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (we_run == CW'(WR_CYC)));

  // R5: data still driven in the cycle after write enable rises
  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> ram_dq_oe);

  // R6: drivers never fight the RAM's output
  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> ram_oe_n);

  // R6: turnaround gap after a read
  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_dq_oe) |-> (since_oe >= CW'(TURN_CYC)));

  // R7: address moves only with write enable high on both sides
  a_r7_addr_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ram_addr) |-> (ram_we_n && $past(ram_we_n)));

  // R8: nothing reaches the address while busy
  a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(ram_addr));

endmodule

// File: tb/asram_bridge_bench.sv
module asram_bridge_bench;

  localparam int RD_N   = (70 + 9) / 10;
  localparam int WR_N   = (70 + 9) / 10;
  localparam int TURN_N = (35 + 9) / 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [14:0] ram_addr;
  logic        ram_ce_n, ram_we_n, ram_oe_n;
  logic [7:0]  ram_dq_out;
  logic        ram_dq_oe;
  logic [7:0]  ram_dq_in;

  asram_bridge u_asram_bridge (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dflt(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]};
  endfunction

  // RAM model
  logic [7:0] ram_mem [int];
  always @(posedge clk)
    if (!ram_ce_n && !ram_we_n && ram_dq_oe) ram_mem[int'(ram_addr)] = ram_dq_out;
  always @* begin
    if (!ram_ce_n && !ram_oe_n && ram_we_n)
      ram_dq_in = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : dflt(ram_addr);
    else
      ram_dq_in = 8'hzz;
  end

  // Scoreboard
  logic [7:0] exp_mem [int];
  logic [7:0] exp_q [$];
  logic [14:0] cur_waddr = '0;
  logic [7:0]  cur_wdata = '0;

  function automatic logic [7:0] exp_read(input logic [14:0] a);
    return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : dflt(a);
  endfunction

  // Monitor
  bit   prev_we = 1, prev_oe = 1, prev_dqoe = 0, prev_rdv = 0, had_read = 0;
  logic [14:0] prev_addr = '0;
  int   we_run = 0, oe_run = 0, gap = 1000, writes_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ram_we_n) begin
        we_run++;
        chk(!ram_ce_n && ram_oe_n, "R4 strobes in write", {ram_ce_n, ram_oe_n}, 2'b01);
        chk(ram_addr == cur_waddr, "R4 write address", ram_addr, cur_waddr);
      end else if (!prev_we) begin
        chk(we_run == WR_N, "R4 write pulse length", we_run, WR_N);
        chk(ram_dq_oe == 1'b1, "R5 data held after write", ram_dq_oe, 1);
        writes_seen++;
        we_run = 0;
      end
      if (ram_dq_oe)
        chk(ram_dq_out == cur_wdata, "R5 write data", ram_dq_out, cur_wdata);
      if (!ram_oe_n) begin
        oe_run++;
        gap = 0;
        had_read = 1;
        chk(ram_we_n && !ram_ce_n, "R2 read strobes", {ram_we_n, ram_ce_n}, 2'b10);
        chk(!ram_dq_oe, "R6 no drive during read", ram_dq_oe, 0);
      end else begin
        if (!prev_oe) begin
          chk(oe_run == RD_N, "R2 read access length", oe_run, RD_N);
          chk(ram_ce_n == 1'b1, "R3 joint release", ram_ce_n, 1);
          chk(rd_valid == 1'b1, "R3 valid after release", rd_valid, 1);
          oe_run = 0;
        end
        if (gap < 1000) gap++;
      end
      if (ram_dq_oe && !prev_dqoe && had_read)
        chk(gap >= TURN_N, "R6 turnaround gap", gap, TURN_N);
      if (ram_addr != prev_addr)
        chk(ram_we_n && prev_we, "R7 address change with we high", {prev_we, ram_we_n}, 2'b11);
      if (rd_valid) begin
        chk(!prev_rdv, "R3 valid single cycle", prev_rdv, 0);
        if (exp_q.size() == 0) chk(0, "R3 unexpected read result", rd_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R3 read data", rd_data, e);
        end
      end
      prev_we = ram_we_n; prev_oe = ram_oe_n; prev_dqoe = ram_dq_oe;
      prev_rdv = rd_valid; prev_addr = ram_addr;
    end
  end

  // Driver
  task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d, input bit stray);
    int busy;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (wr) begin
      cur_waddr = a; cur_wdata = d;
      exp_mem[int'(a)] = d;
    end else begin
      exp_q.push_back(exp_read(a));
    end
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(ram_addr == a, "R2/R4 address presented", ram_addr, a);
    if (wr) chk(ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe, "R4 address setup cycle",
                {ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe}, 4'b1110);
    busy = 0;
    for (int i = 0; i < 4 && stray; i++) begin
      req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h1111; req_wdata = 8'h77;
      busy++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (!req_ready && busy < 100) begin
      busy++;
      @(negedge clk);
    end
    chk(busy == (wr ? WR_N + 2 : RD_N + TURN_N), "R8 ready low length", busy,
        wr ? WR_N + 2 : RD_N + TURN_N);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe, "R1 strobes in reset",
        {ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe}, 4'b1110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe, "R1 strobes after reset",
        {ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe}, 4'b1110);
    chk(req_ready && !rd_valid, "R1 ready and valid", {req_ready, rd_valid}, 2'b10);

    issue(1, 15'h0123, 8'h3C, 0);
    issue(0, 15'h0123, 8'h00, 0);
    issue(0, 15'h7FFF, 8'h00, 0);
    issue(1, 15'h7FFF, 8'hA5, 0);   // write straight after a read: R6
    issue(0, 15'h0000, 8'h00, 0);
    issue(1, 15'h0000, 8'hFF, 0);
    issue(1, 15'h0000, 8'h00, 0);
    issue(0, 15'h0000, 8'h00, 0);
    issue(0, 15'h7FFF, 8'h00, 0);
    for (int k = 0; k < 6; k++) begin
      issue(1, 15'(k * 15'h0A31), 8'(8'h11 * k + 8'h05), 0);
      issue(0, 15'(k * 15'h0A31), 8'h00, 0);
    end
    // R8: stray requests while busy are ignored
    begin
      int w0;
      w0 = writes_seen;
      issue(0, 15'h2222, 8'h00, 1);
      chk(writes_seen == w0, "R8 no write from stray request", writes_seen, w0);
      issue(1, 15'h3333, 8'h42, 1);
      issue(0, 15'h1111, 8'h00, 0);
      issue(0, 15'h3333, 8'h00, 0);
    end
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule